// File: doc/BRIEF.md
# Streamed Multi-Word Program Sequencer

This block drives a bulk programming command for a one-time-programmable word array. A host opens the command with three unlock writes. It then streams data words into a program phase, and after that streams the same words again into a verify phase. The sequencer generates the array addresses by itself. After the first write of a phase, the host sends only a block tag in the upper address bits. A write whose tag matches the start block adds the next word. A write whose tag differs closes the phase.

Each program-phase word produces a word-program request, which is held until an external timer returns a completion pulse. In the verify phase, each resent word is compared with the stored array contents. On a mismatch the word is reprogrammed, up to a bounded number of retries. The command ends with a pass pulse, or in a held error state that only a reset write clears. A ready flag tells the host when the next word may be written. The block also watches for loss of the programming voltage and for writes that arrive while it is busy.

Top module: `bulk_prog_seq`

## Requirements
- R1: The command starts only after three consecutive writes, compared on address bits 10:0 and data bits 7:0: 0xAA at 0x555, then 0x55 at 0x2AA, then 0x20 at 0x555. Any other write during this sequence returns the block to idle without starting an operation.
- R2: A setup write made while `hv_ok` is low is ignored, and the block stays in or returns to idle.
- R3: The first program-phase write loads the start address and the first word. Each later write whose bits 21:17 equal those of the start address supplies the next word at the address one higher. Bits 16:0 of these later writes have no effect, and `prog_addr` is held while `prog_req` is high.
- R4: A write whose bits 21:17 differ from the start address closes the phase without programming anything. A phase of n words therefore takes n+1 writes.
- R5: The verify phase takes the same write pattern as the program phase and compares each resent word with `arr_rdata` at `prog_addr`. A closing write with no error pulses `op_pass` for one cycle, and the block returns to idle.
- R6: `rdy_n` is 0 only while the block waits for a phase write. It is 1 while a word is being programmed or compared. `prog_req` stays high until `prog_done` arrives.
- R7: If `hv_ok` goes low while an operation runs, the operation aborts, `err_flag` and `hv_err_flag` are both set, and `op_active` stays high.
- R8: While an operation runs, every write is treated as phase data. A data value of 0xF0 does not abort or pause the operation.
- R9: On a verify mismatch, `vfy_miss` pulses and the word is reprogrammed, at most MAX_RETRY times per word (default 25). A mismatch after the last retry sets `err_flag` with `hv_err_flag` clear, ends the verify phase, and keeps `op_active` high.
- R10: A write that arrives while `rdy_n` is 1 during an operation is dropped, and it sets the sticky `proto_err`. Only reset clears `proto_err`.
- R11: In the error state, only a write with data bits 7:0 equal to 0xF0 and `hv_ok` high clears both error flags and returns the block to idle. All other writes, including setup writes, are ignored.
- R12: After reset, `rdy_n` is 1, and `op_active`, `prog_req`, `err_flag`, `hv_err_flag` and `proto_err` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_stb | input | 1 | Bus-write strobe, one cycle per write |
| wr_addr | input | 22 | Write address: command address or block tag |
| wr_data | input | 16 | Write data: command byte or data word |
| hv_ok | input | 1 | Programming voltage is at its high level |
| prog_done | input | 1 | Completion pulse for the current word program |
| arr_rdata | input | 16 | Stored array word at `prog_addr` |
| prog_addr | output | 22 | Internal auto-incrementing array address |
| prog_wdata | output | 16 | Word to be programmed |
| prog_req | output | 1 | Word-program request, held until `prog_done` |
| vfy_miss | output | 1 | Verify mismatch seen this cycle |
| rdy_n | output | 1 | 0 when the next phase write may be made |
| op_active | output | 1 | Operation running or held in error |
| op_pass | output | 1 | One-cycle pulse on successful completion |
| err_flag | output | 1 | General error flag |
| hv_err_flag | output | 1 | Programming-voltage error flag |
| proto_err | output | 1 | Sticky flag for a write made while busy |

## Verification
The bench targets tag decoding. It sends random low address bits on every continue write and flips a single tag bit, either at the bottom or at the top of the tag field, on the closing write. A design that compares too many or too few bits would write extra words or stop early. A weak cell that drops its first program must cost exactly one extra request. A cell that can never match must cost exactly MAX_RETRY requests before the error. An off-by-one retry limit shows up as a wrong request count. The bench also drops the voltage in the middle of a burn, writes while the block is busy, and sends 0xF0 both as data and as the only escape from the error state. A design that treats 0xF0 as an abort, lets a busy write through, or leaves the error state on a setup write would change the array contents or the flags.

// File: rtl/bps_pkg.sv
package bps_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_SU1,
    ST_SU2,
    ST_PG_FIRST,
    ST_PG_BURN,
    ST_PG_NEXT,
    ST_VF_FIRST,
    ST_VF_CMP,
    ST_VF_BURN,
    ST_VF_NEXT,
    ST_FAIL
  } bps_state_e;

  localparam logic [10:0] UNLK_ADDR_A = 11'h555;
  localparam logic [10:0] UNLK_ADDR_B = 11'h2AA;
  localparam logic [7:0]  UNLK_DAT_A  = 8'hAA;
  localparam logic [7:0]  UNLK_DAT_B  = 8'h55;
  localparam logic [7:0]  CMD_BULK    = 8'h20;
  localparam logic [7:0]  CMD_RESET   = 8'hF0;

  typedef struct packed {
    logic ld;
    logic inc;
    logic rc_clr;
    logic rc_inc;
    logic set_err;
    logic set_hv;
    logic clr_err;
    logic set_proto;
  } bps_ctl_t;

endpackage

// File: rtl/bps_addr.sv
module bps_addr #(
  parameter int ADDR_W = 22,
  parameter int DATA_W = 16,
  parameter int TAG_LO = 17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld,
  input  logic              inc,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [ADDR_W-1:0] cur_addr,
  output logic [DATA_W-1:0] cur_data,
  output logic              tag_match
);
  localparam int TAG_W = ADDR_W - TAG_LO;

  logic [TAG_W-1:0]  tag_q, tag_d;
  logic [ADDR_W-1:0] addr_d;
  logic [DATA_W-1:0] data_d;

  always_comb begin
    tag_d  = tag_q;
    addr_d = cur_addr;
    data_d = cur_data;
    if (ld) begin
      tag_d  = wr_addr[ADDR_W-1:TAG_LO];
      addr_d = wr_addr;
      data_d = wr_data;
    end else if (inc) begin
      addr_d = cur_addr + 1'b1;
      data_d = wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tag_q    <= '0;
      cur_addr <= '0;
      cur_data <= '0;
    end else if (ld || inc) begin
      tag_q    <= tag_d;
      cur_addr <= addr_d;
      cur_data <= data_d;
    end
  end

  assign tag_match = (wr_addr[ADDR_W-1:TAG_LO] == tag_q);

endmodule

// File: rtl/bps_retry.sv
module bps_retry #(
  parameter int MAX_RETRY = 25
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic inc,
  output logic at_limit
);
  localparam int CW = $clog2(MAX_RETRY + 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr)      cnt_d = '0;
    else if (inc) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt_q <= '0;
    else if (clr || inc) cnt_q <= cnt_d;
  end

  assign at_limit = (cnt_q == CW'(MAX_RETRY));

endmodule

// File: rtl/bps_ctrl.sv
module bps_ctrl
  import bps_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_stb,
  input  logic [10:0] cmd_addr,
  input  logic [7:0]  cmd_byte,
  input  logic        hv_ok,
  input  logic        prog_done,
  input  logic        tag_match,
  input  logic        data_eq,
  input  logic        at_limit,
  output bps_ctl_t    ctl,
  output logic        prog_req,
  output logic        rdy_n,
  output logic        op_active,
  output logic        vfy_miss,
  output logic        op_pass
);
  bps_state_e st_q, st_d;
  logic       in_op, busy_st, wait_st;

  assign in_op   = st_q inside {ST_PG_FIRST, ST_PG_BURN, ST_PG_NEXT,
                                ST_VF_FIRST, ST_VF_CMP, ST_VF_BURN, ST_VF_NEXT};
  assign busy_st = st_q inside {ST_PG_BURN, ST_VF_CMP, ST_VF_BURN};
  assign wait_st = st_q inside {ST_PG_FIRST, ST_PG_NEXT, ST_VF_FIRST, ST_VF_NEXT};

  always_comb begin
    st_d = st_q;
    ctl  = '0;
    ctl.set_proto = busy_st && wr_stb;
    if (in_op && !hv_ok) begin
      st_d        = ST_FAIL;
      ctl.set_err = 1'b1;
      ctl.set_hv  = 1'b1;
    end else begin
      case (st_q)
        ST_IDLE: begin
          if (wr_stb && hv_ok && cmd_addr == UNLK_ADDR_A && cmd_byte == UNLK_DAT_A)
            st_d = ST_SU1;
        end
        ST_SU1: begin
          if (wr_stb)
            st_d = (hv_ok && cmd_addr == UNLK_ADDR_B && cmd_byte == UNLK_DAT_B)
                   ? ST_SU2 : ST_IDLE;
        end
        ST_SU2: begin
          if (wr_stb)
            st_d = (hv_ok && cmd_addr == UNLK_ADDR_A && cmd_byte == CMD_BULK)
                   ? ST_PG_FIRST : ST_IDLE;
        end
        ST_PG_FIRST: begin
          if (wr_stb) begin
            ctl.ld = 1'b1;
            st_d   = ST_PG_BURN;
          end
        end
        ST_PG_BURN: begin
          if (prog_done) st_d = ST_PG_NEXT;
        end
        ST_PG_NEXT: begin
          if (wr_stb) begin
            if (tag_match) begin
              ctl.inc = 1'b1;
              st_d    = ST_PG_BURN;
            end else begin
              st_d = ST_VF_FIRST;
            end
          end
        end
        ST_VF_FIRST: begin
          if (wr_stb) begin
            ctl.ld     = 1'b1;
            ctl.rc_clr = 1'b1;
            st_d       = ST_VF_CMP;
          end
        end
        ST_VF_CMP: begin
          if (data_eq) begin
            st_d = ST_VF_NEXT;
          end else if (at_limit) begin
            ctl.set_err = 1'b1;
            st_d        = ST_FAIL;
          end else begin
            ctl.rc_inc = 1'b1;
            st_d       = ST_VF_BURN;
          end
        end
        ST_VF_BURN: begin
          if (prog_done) st_d = ST_VF_CMP;
        end
        ST_VF_NEXT: begin
          if (wr_stb) begin
            if (tag_match) begin
              ctl.inc    = 1'b1;
              ctl.rc_clr = 1'b1;
              st_d       = ST_VF_CMP;
            end else begin
              st_d = ST_IDLE;
            end
          end
        end
        ST_FAIL: begin
          if (wr_stb && hv_ok && cmd_byte == CMD_RESET) begin
            ctl.clr_err = 1'b1;
            st_d        = ST_IDLE;
          end
        end
        default: st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  assign prog_req  = (st_q == ST_PG_BURN) || (st_q == ST_VF_BURN);
  assign rdy_n     = !wait_st;
  assign op_active = in_op || (st_q == ST_FAIL);
  assign vfy_miss  = (st_q == ST_VF_CMP) && !data_eq && hv_ok;
  assign op_pass   = (st_q == ST_VF_NEXT) && wr_stb && hv_ok && !tag_match;

endmodule

// File: rtl/bulk_prog_seq.sv
module bulk_prog_seq
  import bps_pkg::*;
#(
  parameter int ADDR_W    = 22,
  parameter int DATA_W    = 16,
  parameter int TAG_LO    = 17,
  parameter int MAX_RETRY = 25
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              hv_ok,
  input  logic              prog_done,
  input  logic [DATA_W-1:0] arr_rdata,
  output logic [ADDR_W-1:0] prog_addr,
  output logic [DATA_W-1:0] prog_wdata,
  output logic              prog_req,
  output logic              vfy_miss,
  output logic              rdy_n,
  output logic              op_active,
  output logic              op_pass,
  output logic              err_flag,
  output logic              hv_err_flag,
  output logic              proto_err
);
  logic [1:0] rst_pipe;
  logic       rst_q_n;
  bps_ctl_t   ctl;
  logic       tag_match, data_eq, at_limit;
  logic       err_d, hv_d, proto_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_q_n = rst_pipe[1];

  bps_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_q_n),
    .wr_stb    (wr_stb),
    .cmd_addr  (wr_addr[10:0]),
    .cmd_byte  (wr_data[7:0]),
    .hv_ok     (hv_ok),
    .prog_done (prog_done),
    .tag_match (tag_match),
    .data_eq   (data_eq),
    .at_limit  (at_limit),
    .ctl       (ctl),
    .prog_req  (prog_req),
    .rdy_n     (rdy_n),
    .op_active (op_active),
    .vfy_miss  (vfy_miss),
    .op_pass   (op_pass)
  );

  bps_addr #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .TAG_LO(TAG_LO)) u_addr (
    .clk       (clk),
    .rst_n     (rst_q_n),
    .ld        (ctl.ld),
    .inc       (ctl.inc),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .cur_addr  (prog_addr),
    .cur_data  (prog_wdata),
    .tag_match (tag_match)
  );

  bps_retry #(.MAX_RETRY(MAX_RETRY)) u_retry (
    .clk      (clk),
    .rst_n    (rst_q_n),
    .clr      (ctl.rc_clr),
    .inc      (ctl.rc_inc),
    .at_limit (at_limit)
  );

  assign data_eq = (arr_rdata == prog_wdata);

  always_comb begin
    err_d   = err_flag;
    hv_d    = hv_err_flag;
    proto_d = proto_err | ctl.set_proto;
    if (ctl.clr_err) begin
      err_d = 1'b0;
      hv_d  = 1'b0;
    end else begin
      if (ctl.set_err) err_d = 1'b1;
      if (ctl.set_hv)  hv_d  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      err_flag    <= 1'b0;
      hv_err_flag <= 1'b0;
      proto_err   <= 1'b0;
    end else begin
      err_flag    <= err_d;
      hv_err_flag <= hv_d;
      proto_err   <= proto_d;
    end
  end

endmodule

// File: rtl/bps_chk.sv
module bps_chk #(
  parameter int ADDR_W = 22
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_stb,
  input logic [7:0]        wr_byte,
  input logic              hv_ok,
  input logic [ADDR_W-1:0] prog_addr,
  input logic              prog_req,
  input logic              vfy_miss,
  input logic              rdy_n,
  input logic              op_active,
  input logic              op_pass,
  input logic              err_flag,
  input logic              hv_err_flag,
  input logic              proto_err
);

  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    prog_req |=> (!prog_req || $stable(prog_addr))); // R3

  AST_PASS_ENDS_OP: assert property (@(posedge clk) disable iff (!rst_n)
    op_pass |=> !op_active); // R5

  AST_BURN_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    prog_req |-> rdy_n); // R6

  AST_HV_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    (op_active && !err_flag && !hv_ok) |=> (err_flag && hv_err_flag && op_active)); // R7

  AST_HV_ERR_GEN: assert property (@(posedge clk) disable iff (!rst_n)
    hv_err_flag |-> err_flag); // R7

  AST_MISS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    vfy_miss |-> (rdy_n && !err_flag)); // R9

  AST_PROTO_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err |=> proto_err); // R10

  AST_ERR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (err_flag && !(wr_stb && hv_ok && wr_byte == 8'hF0)) |=> err_flag); // R11

  AST_ERR_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag |-> (!prog_req && op_active)); // R11

endmodule

bind bulk_prog_seq bps_chk #(.ADDR_W(ADDR_W)) u_bps_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .wr_stb      (wr_stb),
  .wr_byte     (wr_data[7:0]),
  .hv_ok       (hv_ok),
  .prog_addr   (prog_addr),
  .prog_req    (prog_req),
  .vfy_miss    (vfy_miss),
  .rdy_n       (rdy_n),
  .op_active   (op_active),
  .op_pass     (op_pass),
  .err_flag    (err_flag),
  .hv_err_flag (hv_err_flag),
  .proto_err   (proto_err)
);

// File: tb/tb_bulk_prog_seq.sv
`timescale 1ns/1ps
module tb_bulk_prog_seq;
  localparam int AW = 22;
  localparam int DW = 16;
  localparam int MR = 25;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst_n, wr_stb, hv_ok, prog_done;
  logic [AW-1:0] wr_addr, prog_addr;
  logic [DW-1:0] wr_data, arr_rdata, prog_wdata;
  logic          prog_req, vfy_miss, rdy_n, op_active, op_pass;
  logic          err_flag, hv_err_flag, proto_err;

  bulk_prog_seq #(.MAX_RETRY(MR)) dut (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data),
    .hv_ok(hv_ok), .prog_done(prog_done), .arr_rdata(arr_rdata),
    .prog_addr(prog_addr), .prog_wdata(prog_wdata), .prog_req(prog_req),
    .vfy_miss(vfy_miss), .rdy_n(rdy_n), .op_active(op_active), .op_pass(op_pass),
    .err_flag(err_flag), .hv_err_flag(hv_err_flag), .proto_err(proto_err)
  );

  logic [15:0] mem [64];
  logic [2:0]  tcnt;
  bit          weak_en, weak_used;
  logic [5:0]  weak_idx;
  int n_chk = 0, n_fail = 0, n_prog = 0, n_miss = 0, n_pass = 0;
  bit done_flag = 0;

  assign arr_rdata = mem[prog_addr[5:0]];

  // array and program timer model: cells only go from 1 to 0
  always @(posedge clk) begin
    if (!prog_req) begin
      tcnt <= 0; prog_done <= 1'b0;
    end else if (prog_done) begin
      prog_done <= 1'b0;
    end else if (tcnt == 3'd3) begin
      prog_done <= 1'b1; tcnt <= 0;
      if (weak_en && prog_addr[5:0] == weak_idx && !weak_used) weak_used <= 1'b1;
      else mem[prog_addr[5:0]] <= mem[prog_addr[5:0]] & prog_wdata;
    end else begin
      tcnt <= tcnt + 3'd1;
    end
  end

  always @(posedge clk) begin
    if (prog_req && prog_done) n_prog++;
    if (vfy_miss) n_miss++;
    if (op_pass) n_pass++;
  end

  function automatic logic [15:0] burn(input logic [15:0] old_v, input logic [15:0] new_v);
    return old_v & new_v;
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    wr_stb = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_stb = 1'b0;
  endtask

  task automatic wait_rdy();
    int g = 0;
    while (rdy_n && !err_flag && g < 3000) begin
      @(negedge clk); g++;
    end
  endtask

  task automatic unlock();
    wr(22'h555, 16'h00AA);
    wr(22'h2AA, 16'h0055);
    wr(22'h555, 16'h0020);
  endtask

  task automatic clr_mem();
    for (int i = 0; i < 64; i++) mem[i] = 16'hFFFF;
  endtask

  function automatic logic [AW-1:0] cont_addr(input logic [AW-1:0] sa);
    return {sa[21:17], 17'($urandom)};
  endfunction

  function automatic logic [AW-1:0] fin_addr(input logic [AW-1:0] sa, input int bitsel);
    return sa ^ (22'd1 << (17 + bitsel));
  endfunction

  logic [15:0] pd [16];

  task automatic phase(input logic [AW-1:0] sa, input int n, input int fbit);
    wait_rdy(); wr(sa, pd[0]);
    for (int i = 1; i < n; i++) begin
      wait_rdy(); wr(cont_addr(sa), pd[i]);
    end
    wait_rdy(); wr(fin_addr(sa, fbit), 16'($urandom));
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done_flag) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    wr_stb = 0; wr_addr = '0; wr_data = '0; hv_ok = 1'b1;
    weak_en = 0; weak_used = 0; weak_idx = '0;
    clr_mem();
    do_reset();

    // R12 reset state
    chk("R12", "rdy_n", rdy_n, 1);
    chk("R12", "op_active", op_active, 0);
    chk("R12", "prog_req", prog_req, 0);
    chk("R12", "err_flag", err_flag, 0);
    chk("R12", "hv_err_flag", hv_err_flag, 0);
    chk("R12", "proto_err", proto_err, 0);

    // R3 R4 R5 R8 random streamed commands
    for (int it = 0; it < 6; it++) begin
      int n, lo, p0, g0, fb;
      logic [AW-1:0] sa;
      clr_mem();
      n  = 1 + $urandom % 8;
      lo = $urandom % 8;
      fb = (it == 0) ? 0 : (it == 1) ? 4 : $urandom % 5;
      sa = {5'($urandom), 17'(lo)};
      for (int i = 0; i < 16; i++) pd[i] = 16'($urandom);
      if (it == 2 && n > 1) pd[1] = 16'h12F0; // R8 reset byte sent as data
      p0 = n_prog; g0 = n_pass;
      unlock();
      phase(sa, n, fb);
      phase(sa, n, $urandom % 5);
      repeat (3) @(negedge clk);
      chk("R5", "pass pulses", n_pass - g0, 1);
      chk("R5", "err_flag", err_flag, 0);
      chk("R5", "op_active", op_active, 0);
      chk("R4", "programs", n_prog - p0, n);
      for (int i = 0; i < n; i++) chk("R3", "word", mem[lo + i], burn(16'hFFFF, pd[i]));
      chk("R4", "word past end", mem[lo + n], 16'hFFFF);
      if (lo > 0) chk("R3", "word before start", mem[lo - 1], 16'hFFFF);
    end

    // R1 broken unlock sequence
    wr(22'h555, 16'h00AA); wr(22'h2AB, 16'h0055); wr(22'h555, 16'h0020);
    wr(22'h0, 16'h1234);
    repeat (2) @(negedge clk);
    chk("R1", "op_active after bad unlock", op_active, 0);
    chk("R1", "rdy_n after bad unlock", rdy_n, 1);

    // R2 unlock with voltage low
    hv_ok = 1'b0;
    unlock();
    hv_ok = 1'b1;
    repeat (2) @(negedge clk);
    chk("R2", "op_active with hv low", op_active, 0);

    // R1 good unlock, then R7 voltage drop mid burn
    clr_mem();
    unlock();
    @(negedge clk);
    chk("R1", "op_active after unlock", op_active, 1);
    chk("R1", "rdy_n after unlock", rdy_n, 0);
    wr(22'h0_0002, 16'hA5A5);
    hv_ok = 1'b0;
    repeat (2) @(negedge clk);
    chk("R7", "err_flag", err_flag, 1);
    chk("R7", "hv_err_flag", hv_err_flag, 1);
    chk("R7", "op_active", op_active, 1);
    chk("R7", "prog_req", prog_req, 0);
    hv_ok = 1'b1;
    // R11 only the reset byte leaves the error state
    wr(22'h0, 16'h5555);
    unlock();
    @(negedge clk);
    chk("R11", "err kept", err_flag, 1);
    chk("R11", "op kept", op_active, 1);
    wr(22'h0, 16'h00F0);
    @(negedge clk);
    chk("R11", "err cleared", err_flag, 0);
    chk("R11", "hv err cleared", hv_err_flag, 0);
    chk("R11", "op ended", op_active, 0);

    // R10 write while busy is dropped
    begin
      logic [AW-1:0] sa;
      int g0;
      clr_mem();
      sa = {5'h0B, 17'd4};
      pd[0] = 16'h3C3C;
      g0 = n_pass;
      unlock();
      wait_rdy(); wr(sa, pd[0]);
      wr(cont_addr(sa), 16'h0000); // lands in the burn
      @(negedge clk);
      chk("R10", "proto_err set", proto_err, 1);
      wait_rdy(); wr(fin_addr(sa, 2), 16'h0);
      phase(sa, 1, 3);
      repeat (3) @(negedge clk);
      chk("R10", "pass despite drop", n_pass - g0, 1);
      chk("R10", "word", mem[4], 16'h3C3C);
      chk("R10", "dropped word no effect", mem[5], 16'hFFFF);
      chk("R10", "proto_err sticky", proto_err, 1);
    end

    // R9 weak cell: one retry then pass
    begin
      logic [AW-1:0] sa;
      int p0, m0, g0;
      clr_mem();
      weak_en = 1; weak_used = 0; weak_idx = 6'd11;
      sa = {5'h13, 17'd10};
      for (int i = 0; i < 3; i++) pd[i] = 16'($urandom) & 16'h7FFF;
      p0 = n_prog; m0 = n_miss; g0 = n_pass;
      unlock();
      phase(sa, 3, 1);
      phase(sa, 3, 1);
      repeat (3) @(negedge clk);
      weak_en = 0;
      chk("R9", "one mismatch", n_miss - m0, 1);
      chk("R9", "programs incl retry", n_prog - p0, 4);
      chk("R9", "pass", n_pass - g0, 1);
      chk("R9", "weak word fixed", mem[11], pd[1]);
    end

    // R9 unreachable value: retry limit then error
    begin
      logic [AW-1:0] sa;
      int p0, m0;
      clr_mem();
      sa = {5'h05, 17'd20};
      unlock();
      wait_rdy(); wr(sa, 16'h00FF);
      wait_rdy(); wr(fin_addr(sa, 0), 16'h0);
      p0 = n_prog; m0 = n_miss;
      wait_rdy(); wr(sa, 16'h0FFF);
      wait_rdy();
      repeat (2) @(negedge clk);
      chk("R9", "err_flag", err_flag, 1);
      chk("R9", "hv_err_flag", hv_err_flag, 0);
      chk("R9", "op_active", op_active, 1);
      chk("R9", "retries", n_prog - p0, MR);
      chk("R9", "mismatches", n_miss - m0, MR + 1);
      chk("R6", "rdy_n in error", rdy_n, 1);
      chk("R9", "cell unchanged", mem[20], 16'h00FF);
      wr(22'h0, 16'h00F0);
      @(negedge clk);
      chk("R11", "err cleared", err_flag, 0);
    end

    // R10 reset clears sticky flag
    do_reset();
    chk("R10", "proto_err after reset", proto_err, 0);

    done_flag = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule